// File: doc/BRIEF.md
# Four-Channel Reload-Start PWM Timer

This block is an 8-bit up-counter that drives four pulse-width-modulated outputs. All four outputs run at one shared frequency. The period is not set by a terminal count. Instead, each period starts from a programmable start value and counts up to the all-ones value. The output period is therefore `256 - start` counter ticks. At the wrap, every enabled output moves to its active level. Each output then returns to its idle level when the counter reaches that channel's own compare value.

Software programs the block through a small write-only register port:

| Address | Register | Contents |
|---------|----------|----------|
| 0 | start value | 8-bit period start value |
| 1 | control | enable bits in data[3:0], polarity bits in data[7:4] |
| 2..5 | compare | compare values for channels 0..3 |

A count-enable input sets the tick rate, and a halt input freezes the timer. A one-cycle wrap pulse marks the start of each period, so surrounding logic can align to it.

Top module: `arpwm_timer`

## Requirements
- R1: While ticking continuously, consecutive `wrap_pulse` outputs are `256 - start` cycles apart. `wrap_pulse` is high for exactly one cycle, in the cycle after the counter has held 255 on a tick.
- R2: A write to the start value (address 0) takes effect only when the counter wraps. The period that contains the write keeps its old length. After reset, the first period counts from 0, so the first `wrap_pulse` comes 256 ticks after reset is released.
- R3: With polarity 0, an enabled channel goes high at the wrap. It returns low on the tick at which the counter reaches the channel's compare value. When compare > start, it is high for `compare - start` cycles of each period.
- R4: When compare equals start, the channel stays at its idle level for the whole period. When compare is below start, the channel stays at its active level for the whole period.
- R5: A polarity bit of 1 inverts both levels of its channel. With start 0, a compare of 0 gives 0% duty at polarity 0 and 100% duty at polarity 1.
- R6: A channel whose enable bit (control data[3:0], bit n for channel n) is 0 drives 0, whatever its polarity. The enable and polarity bits act from the cycle after the write.
- R7: A write to a compare register (address 2+n for channel n) does not change the current period. It takes effect from the next wrap.
- R8: The counter advances only in cycles where `cnt_en` is high. With `cnt_en` high every other cycle, the period in clock cycles doubles.
- R9: While `halt` is high, the counter, every PWM output and `wrap_pulse` hold still. Each halted cycle lengthens the current period by one cycle.
- R10: Reset is synchronous and active high. It clears the counter, the start value, the compare values and the enable and polarity bits. The outputs read 0 during and right after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable; the counter ticks only when high |
| halt | input | 1 | Freezes the counter and the outputs while high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 start value, 1 control, 2..5 compare for channels 0..3 |
| wr_data | input | 8 | Write data |
| pwm_out | output | 4 | PWM outputs, bit n is channel n |
| wrap_pulse | output | 1 | One-cycle pulse at the start of each period |

## Verification
The assertion that outputs hold during halt assumes that no register write arrives in the same cycle. A control write legitimately changes an output at once, even while halted, so the bench never writes while `halt` is high. The wrap-pulse property assumes `cnt_en` and `halt` are sampled in the cycle before the pulse. The bench changes these two inputs only at falling clock edges, and it restores them to a plain ticking state between scenarios. Compare and start values are always written a full period before they are measured, or written on purpose in the middle of a period to exercise the shadowing.

// File: rtl/arpwm_pkg.sv
`timescale 1ns/1ps
package arpwm_pkg;

    localparam int DEF_CNT_W  = 8;
    localparam int DEF_NUM_CH = 4;
    localparam int ADDR_W     = 3;

    // Register address map; compare registers follow ADDR_CMP_BASE.
    typedef enum logic [ADDR_W-1:0] {
        ADDR_START    = 3'd0,
        ADDR_CTRL     = 3'd1,
        ADDR_CMP_BASE = 3'd2
    } reg_addr_e;

    // Counter events broadcast to every channel.
    typedef struct packed {
        logic tick;   // counter advances on this edge
        logic wrap;   // counter is at its maximum and reloads on this edge
    } cnt_evt_t;

    // Address of the compare register of channel idx.
    function automatic logic [ADDR_W-1:0] cmp_addr(input int idx);
        return ADDR_W'(int'(ADDR_CMP_BASE) + idx);
    endfunction

endpackage

// File: rtl/arpwm_regfile.sv
`timescale 1ns/1ps
module arpwm_regfile
    import arpwm_pkg::*;
#(
    parameter int CNT_W  = DEF_CNT_W,
    parameter int NUM_CH = DEF_NUM_CH
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [CNT_W-1:0]              wr_data,
    output logic [CNT_W-1:0]              start_q,
    output logic [NUM_CH-1:0]             en_q,
    output logic [NUM_CH-1:0]             pol_q,
    output logic [NUM_CH-1:0][CNT_W-1:0]  cmp_q
);

    localparam int POL_LSB = NUM_CH;
    localparam int POL_MSB = 2 * NUM_CH - 1;

    // Start value register; the counter samples it at the wrap.
    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
        end else if (wr_en && wr_addr == ADDR_START) begin
            start_q <= wr_data;
        end
    end

    // Control register: enables in the low field, polarities above them.
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            pol_q <= '0;
        end else if (wr_en && wr_addr == ADDR_CTRL) begin
            en_q  <= wr_data[NUM_CH-1:0];
            pol_q <= wr_data[POL_MSB:POL_LSB];
        end
    end

    // Compare registers, one per channel; the channel shadows them.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
        localparam logic [ADDR_W-1:0] SLOT = cmp_addr(g);
        always_ff @(posedge clk) begin
            if (rst) begin
                cmp_q[g] <= '0;
            end else if (wr_en && wr_addr == SLOT) begin
                cmp_q[g] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/arpwm_counter.sv
`timescale 1ns/1ps
module arpwm_counter
    import arpwm_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             halt,
    input  logic [CNT_W-1:0] start_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] nxt_cnt,
    output cnt_evt_t         evt,
    output logic             wrap_pulse
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic at_max;

    always_comb begin
        at_max   = (cnt_q == CNT_MAX);
        evt.tick = cnt_en & ~halt;
        evt.wrap = evt.tick & at_max;
        nxt_cnt  = at_max ? start_val : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            wrap_pulse <= 1'b0;
        end else begin
            wrap_pulse <= evt.wrap;
            if (evt.tick) begin
                cnt_q <= nxt_cnt;
            end
        end
    end

endmodule

// File: rtl/arpwm_channel.sv
`timescale 1ns/1ps
module arpwm_channel
    import arpwm_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_evt_t         evt,
    input  logic [CNT_W-1:0] nxt_cnt,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             en,
    input  logic             pol,
    output logic             pwm
);

    logic [CNT_W-1:0] cmp_act_q;   // compare value in force this period
    logic             act_q;       // channel at its active level

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_act_q <= '0;
            act_q     <= 1'b0;
        end else if (evt.tick) begin
            if (evt.wrap) begin
                // New period: take the shadowed compare, go active unless
                // the start value already matches it.
                cmp_act_q <= cmp_val;
                act_q     <= (nxt_cnt != cmp_val);
            end else if (nxt_cnt == cmp_act_q) begin
                act_q <= 1'b0;
            end
        end
    end

    assign pwm = en & (act_q ^ pol);

endmodule

// File: rtl/arpwm_timer.sv
`timescale 1ns/1ps
module arpwm_timer
    import arpwm_pkg::*;
#(
    parameter int CNT_W  = DEF_CNT_W,
    parameter int NUM_CH = DEF_NUM_CH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en,
    input  logic              halt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [NUM_CH-1:0] pwm_out,
    output logic              wrap_pulse
);

    logic [CNT_W-1:0]             start_q;
    logic [NUM_CH-1:0]            en_q;
    logic [NUM_CH-1:0]            pol_q;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0]             cnt_q;
    logic [CNT_W-1:0]             nxt_cnt;
    cnt_evt_t                     evt;

    arpwm_regfile #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .start_q (start_q),
        .en_q    (en_q),
        .pol_q   (pol_q),
        .cmp_q   (cmp_q)
    );

    arpwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .cnt_en     (cnt_en),
        .halt       (halt),
        .start_val  (start_q),
        .cnt_q      (cnt_q),
        .nxt_cnt    (nxt_cnt),
        .evt        (evt),
        .wrap_pulse (wrap_pulse)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        arpwm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .evt     (evt),
            .nxt_cnt (nxt_cnt),
            .cmp_val (cmp_q[g]),
            .en      (en_q[g]),
            .pol     (pol_q[g]),
            .pwm     (pwm_out[g])
        );
    end

endmodule

// File: rtl/arpwm_timer_chk.sv
`timescale 1ns/1ps
module arpwm_timer_chk
    import arpwm_pkg::*;
#(
    parameter int CNT_W  = DEF_CNT_W,
    parameter int NUM_CH = DEF_NUM_CH
) (
    input logic              clk,
    input logic              rst,
    input logic              cnt_en,
    input logic              halt,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]  wr_data,
    input logic [NUM_CH-1:0] pwm_out,
    input logic              wrap_pulse,
    input logic [CNT_W-1:0]  cnt_q
);

    // R9
    halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (halt && !wr_en) |=> ($stable(pwm_out) && !wrap_pulse));

    // R8
    no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> !wrap_pulse);

    // R6
    disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_CTRL) |=>
            ((pwm_out & ~$past(wr_data[NUM_CH-1:0])) == '0));

    // R10
    reset_out_chk: assert property (@(posedge clk)
        rst |=> (pwm_out == '0 && !wrap_pulse));

    // R1
    wrap_at_max_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_pulse |-> ($past(cnt_q) == '1 && $past(cnt_en) && !$past(halt)));

endmodule

bind arpwm_timer arpwm_timer_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cnt_en     (cnt_en),
    .halt       (halt),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .pwm_out    (pwm_out),
    .wrap_pulse (wrap_pulse),
    .cnt_q      (cnt_q)
);

// File: tb/arpwm_timer_tb.sv
`timescale 1ns/1ps
module arpwm_timer_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       cnt_en;
    logic       halt;
    logic       wr_en;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;
    logic [3:0] pwm_out;
    logic       wrap_pulse;

    int checks = 0;
    int errors = 0;
    int per_len;
    int hi [4];
    int frz_bad;

    always #2.5 clk = ~clk;

    arpwm_timer u_dut (
        .clk        (clk),
        .rst        (rst),
        .cnt_en     (cnt_en),
        .halt       (halt),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .pwm_out    (pwm_out),
        .wrap_pulse (wrap_pulse)
    );

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Measures one period, from one wrap pulse up to the next. It can
    // write mid-period, freeze with halt, or gate the count enable.
    task automatic measure(input bit do_wr, input logic [2:0] a, input logic [7:0] d,
                           input int halt_len, input bit gappy);
        logic [3:0] frz = '0;
        while (wrap_pulse !== 1'b1) @(negedge clk);
        per_len = 0;
        frz_bad = 0;
        for (int i = 0; i < 4; i++) hi[i] = 0;
        do begin
            per_len++;
            for (int ch = 0; ch < 4; ch++) hi[ch] += int'(pwm_out[ch]);
            if (halt_len > 0 && per_len > 5 && per_len <= 5 + halt_len && pwm_out !== frz)
                frz_bad++;
            if (halt_len > 0 && per_len == 5) begin
                halt = 1'b1;
                frz  = pwm_out;
            end
            if (halt_len > 0 && per_len == 5 + halt_len) halt = 1'b0;
            if (do_wr && per_len == 1) begin
                wr_en   = 1'b1;
                wr_addr = a;
                wr_data = d;
            end else begin
                wr_en = 1'b0;
            end
            if (gappy) cnt_en = ~cnt_en;
            @(negedge clk);
        end while (wrap_pulse !== 1'b1 && per_len < 4000);
        cnt_en = 1'b1;
        halt   = 1'b0;
        wr_en  = 1'b0;
    endtask

    task automatic settle();
        measure(1'b0, 3'd0, 8'd0, 0, 1'b0);
    endtask

    task automatic t_reset();
        int k = 0;
        rst = 1'b1; cnt_en = 1'b1; halt = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (4) @(negedge clk);
        chk_eq("R10", "pwm during reset", int'(pwm_out), 0);
        chk_eq("R10", "wrap during reset", int'(wrap_pulse), 0);
        rst     = 1'b0;
        wr_en   = 1'b1;
        wr_addr = 3'd0;
        wr_data = 8'h80;
        do begin
            @(negedge clk);
            wr_en = 1'b0;
            k++;
        end while (wrap_pulse !== 1'b1 && k < 1000);
        chk_eq("R2", "first wrap after reset", k, 256);
        measure(1'b0, 3'd0, 8'd0, 0, 1'b0);
        chk_eq("R2", "period after start write", per_len, 128);
    endtask

    task automatic t_basic();
        wr(3'd2, 8'hA0);
        wr(3'd3, 8'h81);
        wr(3'd4, 8'hFF);
        wr(3'd5, 8'hC0);
        wr(3'd1, 8'h0F);
        settle();
        measure(1'b0, 3'd0, 8'd0, 0, 1'b0);
        chk_eq("R1", "period start 0x80", per_len, 128);
        chk_eq("R3", "ch0 high cmp 0xA0", hi[0], 32);
        chk_eq("R3", "ch1 high cmp 0x81", hi[1], 1);
        chk_eq("R3", "ch2 high cmp 0xFF", hi[2], 127);
        chk_eq("R3", "ch3 high cmp 0xC0", hi[3], 64);
    endtask

    task automatic t_edges();
        wr(3'd2, 8'h80);
        wr(3'd3, 8'h10);
        wr(3'd4, 8'hA0);
        wr(3'd5, 8'h40);
        wr(3'd1, 8'hC7);   // enables 0..2, polarity on ch2 and ch3
        settle();
        measure(1'b0, 3'd0, 8'd0, 0, 1'b0);
        chk_eq("R4", "cmp equal start stays idle", hi[0], 0);
        chk_eq("R4", "cmp below start stays active", hi[1], 128);
        chk_eq("R5", "inverted ch2 high count", hi[2], 96);
        chk_eq("R6", "disabled ch3 with polarity 1", hi[3], 0);
    endtask

    task automatic t_full();
        wr(3'd0, 8'h00);
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h00);
        wr(3'd4, 8'hFF);
        wr(3'd5, 8'h01);
        wr(3'd1, 8'hAF);   // all enabled, polarity on ch1 and ch3
        settle();
        measure(1'b0, 3'd0, 8'd0, 0, 1'b0);
        chk_eq("R1", "period start 0", per_len, 256);
        chk_eq("R5", "0 percent at polarity 0", hi[0], 0);
        chk_eq("R5", "100 percent at polarity 1", hi[1], 256);
        chk_eq("R3", "cmp 0xFF start 0", hi[2], 255);
        chk_eq("R5", "inverted cmp 0x01", hi[3], 255);
    endtask

    task automatic t_cmp_shadow();
        wr(3'd1, 8'h0F);
        wr(3'd2, 8'h40);
        settle();
        measure(1'b1, 3'd2, 8'hC0, 0, 1'b0);
        chk_eq("R7", "period with compare write", hi[0], 64);
        measure(1'b0, 3'd0, 8'd0, 0, 1'b0);
        chk_eq("R7", "period after compare write", hi[0], 192);
    endtask

    task automatic t_start_shadow();
        measure(1'b1, 3'd0, 8'hF0, 0, 1'b0);
        chk_eq("R2", "period with start write", per_len, 256);
        measure(1'b0, 3'd0, 8'd0, 0, 1'b0);
        chk_eq("R2", "period after start write", per_len, 16);
    endtask

    task automatic t_gaps();
        measure(1'b0, 3'd0, 8'd0, 0, 1'b1);
        chk_eq("R8", "period with enable every other cycle", per_len, 32);
    endtask

    task automatic t_halt();
        measure(1'b0, 3'd0, 8'd0, 10, 1'b0);
        chk_eq("R9", "period with 10 halted cycles", per_len, 26);
        chk_eq("R9", "outputs moved during halt", frz_bad, 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_edges();
        t_full();
        t_cmp_shadow();
        t_start_shadow();
        t_gaps();
        t_halt();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule